// File: doc/BRIEF.md
# Reservation Monitor for Linked Load / Conditional Store

This block keeps the single reservation that one processor holds for an atomic read-modify-write built from a linked load and a conditional store. A linked load records the cache block of its address and marks the reservation live. A later conditional store to the same block writes memory and reports success only if nothing broke the reservation in between. If it does not pass, its write is suppressed and it reports failure.

Three things break a live reservation. The first is a snooped invalidation or foreign store that hits the reserved block. The second is an exception, interrupt or context-switch strobe. The third is any conditional store, whether it passed or not. Blocks are `2**OFS_W` bytes (16 by default), so the low `OFS_W` address bits never take part in a compare.

The command, snoop and exception inputs are sampled on a rising clock edge. The result appears on registered outputs one cycle later, as single-cycle pulses. Memory data paths and the pipeline are outside the block.

Top module: `llsc_monitor`

## Requirements
- R1: After reset there is no live reservation, and `sc_done_o`, `sc_ok_o` and `mem_we_o` are 0.
- R2: A linked load (`cmd_op_i`=0) followed by a conditional store (`cmd_op_i`=1) to the same block reports `sc_done_o`=1, `sc_ok_o`=1 and `mem_we_o`=1 in the cycle after the store is sampled. Any offset in the low `OFS_W` bits counts as the same block.
- R3: A conditional store to a different block than the reserved one reports `sc_ok_o`=0 and `mem_we_o`=0.
- R4: A conditional store with no live reservation, including the first one after reset, fails without writing.
- R5: Every conditional store clears the reservation, whether it passed or not, so a second one without a new linked load fails.
- R6: A snoop (`snoop_valid_i`=1) whose address falls in the reserved block clears the reservation. A snoop to any other block leaves it intact.
- R7: An exception strobe (`exc_i`=1) clears the reservation.
- R8: In a single cycle, a snoop hit or exception together with a conditional store makes that store fail. A linked load sampled together with a snoop or exception still sets a live reservation.
- R9: A linked load replaces any earlier reservation. Only the block of the newest linked load can then succeed.
- R10: `mem_we_o` is 1 only when `sc_ok_o` is 1. All three outputs are 0 in a cycle that does not follow a conditional store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 1 | 0 = linked load, 1 = conditional store |
| cmd_addr_i | input | ADDR_W | Command byte address |
| snoop_valid_i | input | 1 | Foreign invalidation or store observed |
| snoop_addr_i | input | ADDR_W | Snooped byte address |
| exc_i | input | 1 | Exception, interrupt or context-switch strobe |
| sc_done_o | output | 1 | Pulse: a conditional store was resolved |
| sc_ok_o | output | 1 | Pulse: that store passed (1) or failed (0) |
| mem_we_o | output | 1 | Pulse: memory write enable for the passing store |

## Verification
The properties assume that reset is held low for at least one clock edge before the first command. They also assume that every input is a known value at each rising edge, so `cmd_op_i` is never X while `cmd_valid_i` is high. The stimulus changes inputs only on falling edges and drives all of them from reset onward. It mixes directed sequences for each ordering case with a long random stretch. That stretch draws addresses from a handful of blocks at random offsets, so snoop hits and misses, block matches and mismatches, and same-cycle collisions all occur often.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic {
        OP_LL = 1'b0,
        OP_SC = 1'b1
    } llsc_op_e;

endpackage

// File: rtl/llsc_blk_cmp.sv
module llsc_blk_cmp #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 4
) (
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [ADDR_W-OFS_W-1:0] blk_i,
    output logic                    hit_o
);
    assign hit_o = (addr_i[ADDR_W-1:OFS_W] == blk_i);

    generate
        if (OFS_W > 0) begin : g_ofs
            logic unused_ofs;
            assign unused_ofs = ^addr_i[OFS_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/llsc_kill.sv
module llsc_kill (
    input  logic res_valid_i,
    input  logic snoop_valid_i,
    input  logic snoop_hit_i,
    input  logic exc_i,
    output logic kill_o
);
    always_comb begin
        kill_o = 1'b0;
        if (res_valid_i) begin
            if (exc_i) begin
                kill_o = 1'b1;
            end else if (snoop_valid_i && snoop_hit_i) begin
                kill_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_valid_i,
    input  logic              cmd_op_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic              snoop_valid_i,
    input  logic [ADDR_W-1:0] snoop_addr_i,
    input  logic              exc_i,
    output logic              sc_done_o,
    output logic              sc_ok_o,
    output logic              mem_we_o
);
    import llsc_pkg::*;

    localparam int BLK_W = ADDR_W - OFS_W;

    typedef struct packed {
        logic             res_valid;
        logic [BLK_W-1:0] res_blk;
        logic             sc_done;
        logic             sc_ok;
        logic             we;
    } state_t;

    state_t st_d, st_q;

    logic is_ll, is_sc;
    logic cmd_hit, snoop_hit, kill;
    logic pass;

    assign is_ll = cmd_valid_i && (llsc_op_e'(cmd_op_i) == OP_LL);
    assign is_sc = cmd_valid_i && (llsc_op_e'(cmd_op_i) == OP_SC);

    llsc_blk_cmp #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_cmd_cmp (
        .addr_i (cmd_addr_i),
        .blk_i  (st_q.res_blk),
        .hit_o  (cmd_hit)
    );

    llsc_blk_cmp #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_snp_cmp (
        .addr_i (snoop_addr_i),
        .blk_i  (st_q.res_blk),
        .hit_o  (snoop_hit)
    );

    llsc_kill i_kill (
        .res_valid_i   (st_q.res_valid),
        .snoop_valid_i (snoop_valid_i),
        .snoop_hit_i   (snoop_hit),
        .exc_i         (exc_i),
        .kill_o        (kill)
    );

    assign pass = is_sc && st_q.res_valid && cmd_hit && !kill;

    always_comb begin
        st_d         = st_q;
        st_d.sc_done = is_sc;
        st_d.sc_ok   = pass;
        st_d.we      = pass;
        if (is_ll) begin
            st_d.res_valid = 1'b1;
            st_d.res_blk   = cmd_addr_i[ADDR_W-1:OFS_W];
        end else if (is_sc || kill) begin
            st_d.res_valid = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sc_done_o = st_q.sc_done;
    assign sc_ok_o   = st_q.sc_ok;
    assign mem_we_o  = st_q.we;
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cmd_valid_i,
    input logic              cmd_op_i,
    input logic [ADDR_W-1:0] cmd_addr_i,
    input logic              snoop_valid_i,
    input logic [ADDR_W-1:0] snoop_addr_i,
    input logic              exc_i,
    input logic              sc_done_o,
    input logic              sc_ok_o,
    input logic              mem_we_o
);
    logic sc_now, snoop_same_blk;
    assign sc_now         = cmd_valid_i && cmd_op_i;
    assign snoop_same_blk = snoop_valid_i &&
        (snoop_addr_i[ADDR_W-1:OFS_W] == cmd_addr_i[ADDR_W-1:OFS_W]);

    // R2: a store command is resolved in the following cycle
    a_r2_sc_resolved: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sc_now |=> sc_done_o);

    // R10: no result pulse without a preceding store command
    a_r10_no_spurious_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sc_now |=> !sc_done_o && !sc_ok_o);

    // R10: a write only for a store command sampled in the previous cycle
    a_r10_we_needs_sc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> $past(sc_now) && sc_ok_o);

    // R5: back-to-back stores, the second one always fails
    a_r5_second_sc_fails: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sc_now ##1 sc_now |=> !sc_ok_o && !mem_we_o);

    // R7 / R8: exception together with a store
    a_r8_exc_with_sc_fails: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sc_now && exc_i) |=> !sc_ok_o && !mem_we_o);

    // R6 / R8: snoop to the store's own block in the same cycle
    a_r8_snoop_with_sc_fails: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sc_now && snoop_same_blk) |=> !mem_we_o);
endmodule

bind llsc_monitor llsc_monitor_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_llsc_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_valid_i   (cmd_valid_i),
    .cmd_op_i      (cmd_op_i),
    .cmd_addr_i    (cmd_addr_i),
    .snoop_valid_i (snoop_valid_i),
    .snoop_addr_i  (snoop_addr_i),
    .exc_i         (exc_i),
    .sc_done_o     (sc_done_o),
    .sc_ok_o       (sc_ok_o),
    .mem_we_o      (mem_we_o)
);

// File: tb/test_llsc_monitor.sv
module test_llsc_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int OW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_op = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic          snoop_valid = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic          exc = 1'b0;
    logic          sc_done, sc_ok, mem_we;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    bit          m_valid;
    int unsigned m_blk;
    string       m_why;
    string       m_succ;

    always #(CLK_PERIOD/2) clk = ~clk;

    llsc_monitor #(.ADDR_W(AW), .OFS_W(OW)) i_llsc_monitor (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .cmd_valid_i   (cmd_valid),
        .cmd_op_i      (cmd_op),
        .cmd_addr_i    (cmd_addr),
        .snoop_valid_i (snoop_valid),
        .snoop_addr_i  (snoop_addr),
        .exc_i         (exc),
        .sc_done_o     (sc_done),
        .sc_ok_o       (sc_ok),
        .mem_we_o      (mem_we)
    );

    task automatic check3(input string tag, input logic [2:0] exp);
        checks++;
        if ({sc_done, sc_ok, mem_we} !== exp) begin
            fails++;
            $display("FAIL %s: done/ok/we actual %b expected %b at %0t",
                     tag, {sc_done, sc_ok, mem_we}, exp, $time);
        end
    endtask

    // drive one cycle of inputs, predict, then compare after the clock edge
    task automatic step(input logic v, input logic op, input logic [AW-1:0] a,
                        input logic sv, input logic [AW-1:0] sa, input logic ex);
        logic [2:0] exp;
        string tag;
        bit kill, match, snp_hit;
        cmd_valid = v; cmd_op = op; cmd_addr = a;
        snoop_valid = sv; snoop_addr = sa; exc = ex;
        snp_hit = sv && m_valid && ((sa >> OW) == m_blk);
        kill = m_valid && (ex || snp_hit);
        exp = 3'b000;
        tag = "R10";
        if (v && op) begin
            match = m_valid && ((a >> OW) == m_blk);
            exp = (match && !kill) ? 3'b111 : 3'b100;
            if (!m_valid)    tag = m_why;
            else if (kill)   tag = "R8";
            else if (!match) tag = (m_succ == "R9") ? "R9" : "R3";
            else             tag = m_succ;
        end
        if (v && !op) begin
            if (ex || sv)   m_succ = "R8";
            else if (m_valid) m_succ = "R9";
            else            m_succ = "R2";
            m_valid = 1'b1;
            m_blk   = a >> OW;
        end else if (v && op) begin
            m_valid = 1'b0;
            m_why   = "R5";
        end else if (m_valid && ex) begin
            m_valid = 1'b0;
            m_why   = "R7";
        end else if (m_valid && snp_hit) begin
            m_valid = 1'b0;
            m_why   = "R6";
        end else if (m_valid && sv) begin
            m_succ = "R6";
        end
        @(negedge clk);
        check3(tag, exp);
    endtask

    task automatic ll(input logic [AW-1:0] a);
        step(1'b1, 1'b0, a, 1'b0, '0, 1'b0);
    endtask

    task automatic sc(input logic [AW-1:0] a);
        step(1'b1, 1'b1, a, 1'b0, '0, 1'b0);
    endtask

    task automatic idle(input logic sv, input logic [AW-1:0] sa, input logic ex);
        step(1'b0, 1'b0, '0, sv, sa, ex);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        m_valid = 1'b0; m_blk = 0; m_why = "R4"; m_succ = "R2";
        repeat (3) @(negedge clk);
        check3("R1", 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check3("R1", 3'b000);

        sc(32'h1000);                                  // R4: no reservation
        ll(32'h1000); idle(1'b0, '0, 1'b0); sc(32'h100C); // R2
        sc(32'h100C);                                  // R5
        ll(32'h1000); sc(32'h1010);                    // R3
        ll(32'h2000); idle(1'b1, 32'h2008, 1'b0); sc(32'h2000); // R6 hit
        ll(32'h2000); idle(1'b1, 32'h3000, 1'b0); sc(32'h2004); // R6 miss
        ll(32'h2000); idle(1'b0, '0, 1'b1); sc(32'h2000);       // R7
        ll(32'h4000); step(1'b1, 1'b1, 32'h4000, 1'b0, '0, 1'b1);         // R8
        ll(32'h4000); step(1'b1, 1'b1, 32'h4000, 1'b1, 32'h400F, 1'b0);   // R8
        step(1'b1, 1'b0, 32'h5000, 1'b0, '0, 1'b1); sc(32'h5000);         // R8
        step(1'b1, 1'b0, 32'h5000, 1'b1, 32'h5000, 1'b0); sc(32'h5004);   // R8
        ll(32'h6000); ll(32'h7000); sc(32'h6000);      // R9 fail
        ll(32'h6000); ll(32'h7000); sc(32'h7008);      // R9 pass
        idle(1'b1, 32'h7000, 1'b0); idle(1'b0, '0, 1'b1); // R10

        for (int i = 0; i < 4000; i++) begin
            logic v, op, sv, ex;
            logic [AW-1:0] a, sa;
            v  = ($urandom_range(0, 3) != 0);
            op = $urandom_range(0, 1);
            sv = ($urandom_range(0, 4) == 0);
            ex = ($urandom_range(0, 15) == 0);
            a  = 32'h8000 + ($urandom_range(0, 3) << OW) + $urandom_range(0, 15);
            sa = 32'h8000 + ($urandom_range(0, 3) << OW) + $urandom_range(0, 15);
            step(v, op, a, sv, sa, ex);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule